// File: doc/BRIEF.md
# Cancellable Shift Queue

A first-in first-out buffer built as a shift register of `DEPTH` slots, each holding a `WIDTH`-bit word and an occupied flag. Words enter through a ready/valid enqueue port and leave through a ready/valid dequeue port. Slot 0 is the head. A separate cancel port holds a strobe and a per-slot bitmask, and can withdraw any queued word before it leaves. A cancelled word is never presented at the dequeue port. A gap that a cancelled word leaves at the head drains by itself, one slot per cycle.

The queue buffers per-lane requests ahead of a merging stage. That stage may absorb some of the queued requests and then withdraw them. A shift-enable input can freeze all movement toward the head. While frozen, the word already at the head can still be taken once. No other word moves forward until shifting resumes.

Top module: `cancel_shift_queue`

## Requirements
- R1: After reset every slot is empty, `deq_valid_o` is low and `enq_ready_o` is high. An empty queue always reports `enq_ready_o` high.
- R2: With no cancels and `shift_en_i` high, words leave in the order they were accepted. A word accepted into an empty queue is at the dequeue port in the next cycle.
- R3: Bit i of `inv_mask_i` addresses slot i, with slot 0 the head. Cancelling a slot behind the head leaves the head and the order of the remaining words unchanged.
- R4: If `inv_valid_i` is high with mask bit 0 set, `deq_valid_o` is low in that same cycle, even with `deq_ready_i` high, and the head word is discarded.
- R5: With `shift_en_i` high, cancelled words are removed without a dequeue handshake. The vacated head closes up one slot per cycle. After cancelling the two oldest of three words, the third word is at the dequeue port two cycles later.
- R6: With `shift_en_i` low, the current head can be dequeued once. After that, `deq_valid_o` stays low while the freeze lasts. The next word appears one cycle after `shift_en_i` returns high.
- R7: With `shift_en_i` low and the last slot occupied at the start of the cycle, `enq_ready_o` is low, even if that slot is being cancelled in the same cycle.
- R8: With `shift_en_i` high, a full queue accepts an enqueue in a cycle in which it also completes a dequeue.
- R9: After cancelled words have drained, the occupied flags are clear. A word enqueued into the empty queue is dequeued with its own value in the next cycle.
- R10: While the head is valid and not taken, `deq_data_o` holds its value.
- R11: With `DEPTH` = 1 the queue behaves the same way: it fills, reports not ready when full, and hands over its one word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enq_valid_i | input | 1 | Enqueue request |
| enq_ready_o | output | 1 | Queue can take a word this cycle |
| enq_data_i | input | WIDTH | Word to enqueue |
| deq_valid_o | output | 1 | Head word available |
| deq_ready_i | input | 1 | Consumer takes the head |
| deq_data_o | output | WIDTH | Head word |
| inv_valid_i | input | 1 | Cancel strobe |
| inv_mask_i | input | DEPTH | Slots to cancel, bit 0 is the head |
| shift_en_i | input | 1 | Allows words to move toward the head |

## Verification
The properties expect every input to be a known value in each cycle after reset. They also expect a cancel bit that points at an empty slot to have no effect. The freeze property assumes that no enqueue happens in the cycle the head is taken, so a new word cannot land directly in slot 0. The stimulus never cancels a slot in a cycle where the head is also handed over, and it cancels only while the queue has no gaps. Under those conditions, mask bit i is the i-th oldest word in the expected-order model.

// File: rtl/csq_pkg.sv
package csq_pkg;
  localparam int unsigned CSQ_WIDTH_DEF = 8;
  localparam int unsigned CSQ_DEPTH_DEF = 4;
endpackage

// File: rtl/csq_head_ctrl.sv
module csq_head_ctrl #(
  parameter int unsigned DEPTH = csq_pkg::CSQ_DEPTH_DEF
) (
  input  logic [DEPTH-1:0] used_i,
  input  logic             inv_valid_i,
  input  logic [DEPTH-1:0] inv_mask_i,
  input  logic             deq_ready_i,
  output logic             deq_valid_o,
  output logic [DEPTH-1:0] keep_o
);
  logic [DEPTH-1:0] kill;
  logic [DEPTH-1:0] live;

  always_comb begin
    kill        = inv_valid_i ? inv_mask_i : '0;
    live        = used_i & ~kill;
    deq_valid_o = live[0];
    keep_o      = live;
    keep_o[0]   = live[0] & ~deq_ready_i;
  end
endmodule

// File: rtl/csq_compact.sv
module csq_compact #(
  parameter int unsigned WIDTH = csq_pkg::CSQ_WIDTH_DEF,
  parameter int unsigned DEPTH = csq_pkg::CSQ_DEPTH_DEF
) (
  input  logic [DEPTH-1:0]            keep_i,
  input  logic [DEPTH-1:0][WIDTH-1:0] data_i,
  input  logic                        shift_en_i,
  output logic [DEPTH-1:0]            used_o,
  output logic [DEPTH-1:0][WIDTH-1:0] data_o
);
  logic shift;
  // advance one slot only when the head is free after removal
  assign shift = shift_en_i & ~keep_i[0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i < DEPTH - 1) begin : g_mid
      assign used_o[i] = shift ? keep_i[i+1] : keep_i[i];
      assign data_o[i] = shift ? data_i[i+1] : data_i[i];
    end else begin : g_top
      assign used_o[i] = shift ? 1'b0 : keep_i[i];
      assign data_o[i] = data_i[i];
    end
  end
endmodule

// File: rtl/csq_tail_alloc.sv
module csq_tail_alloc #(
  parameter int unsigned DEPTH = csq_pkg::CSQ_DEPTH_DEF
) (
  input  logic [DEPTH-1:0] used_i,
  input  logic             top_busy_i,
  input  logic             shift_en_i,
  input  logic             enq_valid_i,
  output logic             enq_ready_o,
  output logic [DEPTH-1:0] wr_sel_o
);
  logic [DEPTH:0]   above;
  logic [DEPTH-1:0] lower;
  logic [DEPTH-1:0] tail;

  if (DEPTH == 1) begin : g_one
    assign lower = 1'b1;
  end else begin : g_many
    assign lower = {used_i[DEPTH-2:0], 1'b1};
  end

  always_comb begin
    above[DEPTH] = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) above[i] = above[i+1] | used_i[i];
  end

  // first free slot above the youngest occupied one
  assign tail        = ~above[DEPTH-1:0] & lower;
  // a frozen queue cannot reuse its last slot this cycle
  assign enq_ready_o = ~used_i[DEPTH-1] & (shift_en_i | ~top_busy_i);
  assign wr_sel_o    = tail & {DEPTH{enq_valid_i & enq_ready_o}};
endmodule

// File: rtl/cancel_shift_queue.sv
module cancel_shift_queue #(
  parameter int unsigned WIDTH = csq_pkg::CSQ_WIDTH_DEF,
  parameter int unsigned DEPTH = csq_pkg::CSQ_DEPTH_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enq_valid_i,
  output logic             enq_ready_o,
  input  logic [WIDTH-1:0] enq_data_i,
  output logic             deq_valid_o,
  input  logic             deq_ready_i,
  output logic [WIDTH-1:0] deq_data_o,
  input  logic             inv_valid_i,
  input  logic [DEPTH-1:0] inv_mask_i,
  input  logic             shift_en_i
);
  logic [DEPTH-1:0]            used_q;
  logic [DEPTH-1:0][WIDTH-1:0] data_q;
  logic [DEPTH-1:0]            keep;
  logic [DEPTH-1:0]            nxt_used;
  logic [DEPTH-1:0][WIDTH-1:0] nxt_data;
  logic [DEPTH-1:0]            wr_sel;

  csq_head_ctrl #(.DEPTH(DEPTH)) u_head (
    .used_i      (used_q),
    .inv_valid_i (inv_valid_i),
    .inv_mask_i  (inv_mask_i),
    .deq_ready_i (deq_ready_i),
    .deq_valid_o (deq_valid_o),
    .keep_o      (keep)
  );

  csq_compact #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_compact (
    .keep_i     (keep),
    .data_i     (data_q),
    .shift_en_i (shift_en_i),
    .used_o     (nxt_used),
    .data_o     (nxt_data)
  );

  csq_tail_alloc #(.DEPTH(DEPTH)) u_tail (
    .used_i      (nxt_used),
    .top_busy_i  (used_q[DEPTH-1]),
    .shift_en_i  (shift_en_i),
    .enq_valid_i (enq_valid_i),
    .enq_ready_o (enq_ready_o),
    .wr_sel_o    (wr_sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q <= '0;
      data_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        used_q[i] <= nxt_used[i] | wr_sel[i];
        data_q[i] <= wr_sel[i] ? enq_data_i : nxt_data[i];
      end
    end
  end

  assign deq_data_o = data_q[0];
endmodule

// File: rtl/csq_checker.sv
module csq_checker #(
  parameter int unsigned WIDTH = csq_pkg::CSQ_WIDTH_DEF,
  parameter int unsigned DEPTH = csq_pkg::CSQ_DEPTH_DEF
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enq_valid_i,
  input logic             enq_ready_o,
  input logic [WIDTH-1:0] enq_data_i,
  input logic             deq_valid_o,
  input logic             deq_ready_i,
  input logic [WIDTH-1:0] deq_data_o,
  input logic             inv_valid_i,
  input logic [DEPTH-1:0] inv_mask_i,
  input logic             shift_en_i,
  input logic [DEPTH-1:0] used_q
);
  a_r1_empty_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (used_q == '0) |-> (enq_ready_o && !deq_valid_o));

  a_r2_next_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enq_valid_i && enq_ready_o && used_q == '0)
      |=> ((deq_valid_o || (inv_valid_i && inv_mask_i[0])) && deq_data_o == $past(enq_data_i)));

  a_r4_head_kill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_valid_i && inv_mask_i[0]) |-> !deq_valid_o);

  a_r6_frozen_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_en_i && deq_valid_o && deq_ready_i && !enq_valid_i)
      |=> (shift_en_i || !deq_valid_o));

  a_r7_frozen_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_en_i && used_q[DEPTH-1]) |-> !enq_ready_o);

  a_r10_head_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deq_valid_o && !deq_ready_i) |=> $stable(deq_data_o));
endmodule

bind cancel_shift_queue csq_checker #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_csq_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enq_valid_i (enq_valid_i),
  .enq_ready_o (enq_ready_o),
  .enq_data_i  (enq_data_i),
  .deq_valid_o (deq_valid_o),
  .deq_ready_i (deq_ready_i),
  .deq_data_o  (deq_data_o),
  .inv_valid_i (inv_valid_i),
  .inv_mask_i  (inv_mask_i),
  .shift_en_i  (shift_en_i),
  .used_q      (used_q)
);

// File: tb/cancel_shift_queue_tb_top.sv
module cancel_shift_queue_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic       e4_v = 0, e4_r, q4_v, q4_r = 0, i4_v = 0, a4 = 1;
  logic [7:0] e4_d = 0, q4_d;
  logic [3:0] i4_m = 0;
  logic       e1_v = 0, e1_r, q1_v, q1_r = 0, i1_v = 0, a1 = 1;
  logic [7:0] e1_d = 0, q1_d;
  logic [0:0] i1_m = 0;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [7:0] exp_q[$];

  cancel_shift_queue #(.WIDTH(8), .DEPTH(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .enq_valid_i(e4_v), .enq_ready_o(e4_r),
    .enq_data_i(e4_d), .deq_valid_o(q4_v), .deq_ready_i(q4_r), .deq_data_o(q4_d),
    .inv_valid_i(i4_v), .inv_mask_i(i4_m), .shift_en_i(a4));

  cancel_shift_queue #(.WIDTH(8), .DEPTH(1)) dut1_i (
    .clk_i(clk), .rst_ni(rst_ni), .enq_valid_i(e1_v), .enq_ready_o(e1_r),
    .enq_data_i(e1_d), .deq_valid_o(q1_v), .deq_ready_i(q1_r), .deq_data_o(q1_d),
    .inv_valid_i(i1_v), .inv_mask_i(i1_m), .shift_en_i(a1));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, then model update at mid-cycle
  task automatic cyc4(logic ev, logic [7:0] ed, logic dr, logic iv, logic [3:0] im, logic al);
    @(posedge clk); #1;
    e4_v = ev; e4_d = ed; q4_r = dr; i4_v = iv; i4_m = im; a4 = al;
    @(negedge clk);
    if (ev && e4_r) exp_q.push_back(ed);
    if (iv) for (int i = 3; i >= 0; i--) if (im[i] && i < exp_q.size()) exp_q.delete(i);
  endtask

  task automatic cyc1(logic ev, logic [7:0] ed, logic dr, logic iv, logic al);
    @(posedge clk); #1;
    e1_v = ev; e1_d = ed; q1_r = dr; i1_v = iv; i1_m = iv; a1 = al;
    @(negedge clk);
  endtask

  // monitor: pops the expected word on each completed dequeue
  always @(negedge clk) begin
    if (rst_ni && q4_v && q4_r) begin
      if (exp_q.size() == 0) check("R2 dequeue with empty model", 1, 0);
      else check("R2 order", q4_d, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R1 deq_valid in reset", q4_v, 0);
    check("R1 enq_ready in reset", e4_r, 1);
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R2 / R10 / R8 fill, full, swap
    cyc4(1, 8'h11, 0, 0, 0, 1); check("R1 ready after reset", e4_r, 1);
    cyc4(1, 8'h22, 0, 0, 0, 1); check("R2 latency valid", q4_v, 1); check("R2 latency data", q4_d, 8'h11);
    cyc4(1, 8'h33, 0, 0, 0, 1); check("R10 head hold", q4_d, 8'h11);
    cyc4(1, 8'h44, 0, 0, 0, 1); check("R2 ready with free slot", e4_r, 1);
    cyc4(0, 8'h00, 0, 0, 0, 1); check("R8 full not ready", e4_r, 0); check("R10 head hold", q4_d, 8'h11);
    cyc4(1, 8'h55, 1, 0, 0, 1); check("R8 full swap ready", e4_r, 1);
    repeat (6) cyc4(0, 0, 1, 0, 0, 1);
    check("R2 drained", q4_v, 0); check("R2 model empty", exp_q.size(), 0);

    // R2 streaming
    for (int k = 0; k < 12; k++) cyc4(1, 8'(k * 13 + 5), 1, 0, 0, 1);
    repeat (2) cyc4(0, 0, 1, 0, 0, 1);
    check("R2 stream model empty", exp_q.size(), 0);

    // R4 head cancelled while ready
    cyc4(1, 8'hA1, 0, 0, 0, 1);
    cyc4(1, 8'hA2, 0, 0, 0, 1);
    cyc4(0, 0, 1, 1, 4'b0001, 1); check("R4 valid low on head cancel", q4_v, 0);
    cyc4(0, 0, 0, 0, 0, 1); check("R4 next valid", q4_v, 1); check("R4 next data", q4_d, 8'hA2);
    cyc4(0, 0, 1, 0, 0, 1);
    cyc4(0, 0, 0, 0, 0, 1); check("R4 model empty", exp_q.size(), 0);

    // R5 two cancelled heads drain
    cyc4(1, 8'hB1, 0, 0, 0, 1);
    cyc4(1, 8'hB2, 0, 0, 0, 1);
    cyc4(1, 8'hB3, 0, 0, 0, 1);
    cyc4(0, 0, 0, 1, 4'b0011, 1); check("R5 cancel cycle", q4_v, 0);
    cyc4(0, 0, 0, 0, 0, 1); check("R5 draining", q4_v, 0);
    cyc4(0, 0, 0, 0, 0, 1); check("R5 survivor valid", q4_v, 1); check("R5 survivor data", q4_d, 8'hB3);
    cyc4(0, 0, 1, 0, 0, 1);

    // R3 cancel behind the head
    cyc4(1, 8'hC1, 0, 0, 0, 1);
    cyc4(1, 8'hC2, 0, 0, 0, 1);
    cyc4(1, 8'hC3, 0, 0, 0, 1);
    cyc4(0, 0, 0, 1, 4'b0010, 1); check("R3 head kept", q4_d, 8'hC1); check("R3 head valid", q4_v, 1);
    repeat (4) cyc4(0, 0, 1, 0, 0, 1);
    check("R3 model empty", exp_q.size(), 0); check("R3 queue empty", q4_v, 0);

    // R9 clean flags after drain
    cyc4(1, 8'hD1, 0, 0, 0, 1);
    cyc4(0, 0, 1, 0, 0, 1); check("R9 valid", q4_v, 1); check("R9 data", q4_d, 8'hD1);

    // R6 freeze
    cyc4(1, 8'hE1, 0, 0, 0, 1);
    cyc4(1, 8'hE2, 0, 0, 0, 1);
    cyc4(0, 0, 1, 0, 0, 0); check("R6 head once", q4_v, 1); check("R6 head data", q4_d, 8'hE1);
    cyc4(0, 0, 1, 0, 0, 0); check("R6 frozen low", q4_v, 0);
    cyc4(0, 0, 1, 0, 0, 0); check("R6 frozen still low", q4_v, 0);
    cyc4(0, 0, 1, 0, 0, 1); check("R6 resume cycle low", q4_v, 0);
    cyc4(0, 0, 1, 0, 0, 1); check("R6 resumed valid", q4_v, 1); check("R6 resumed data", q4_d, 8'hE2);

    // R7 frozen full with cancel of last slot
    cyc4(1, 8'hF1, 0, 0, 0, 1);
    cyc4(1, 8'hF2, 0, 0, 0, 1);
    cyc4(1, 8'hF3, 0, 0, 0, 1);
    cyc4(1, 8'hF4, 0, 0, 0, 1);
    cyc4(1, 8'h99, 0, 1, 4'b1000, 0); check("R7 frozen full not ready", e4_r, 0);
    cyc4(0, 0, 0, 0, 0, 1); check("R7 ready after cancel", e4_r, 1);
    repeat (5) cyc4(0, 0, 1, 0, 0, 1);
    check("R7 model empty", exp_q.size(), 0);

    // R11 depth one
    cyc1(1, 8'h12, 0, 0, 1); check("R11 ready empty", e1_r, 1);
    cyc1(0, 0, 0, 0, 1); check("R11 valid", q1_v, 1); check("R11 data", q1_d, 8'h12); check("R11 full", e1_r, 0);
    cyc1(1, 8'h34, 1, 0, 1); check("R8 depth one swap", e1_r, 1); check("R11 out", q1_d, 8'h12);
    cyc1(0, 0, 0, 0, 1); check("R11 swapped data", q1_d, 8'h34);
    cyc1(0, 0, 0, 1, 0); check("R7 depth one frozen cancel", e1_r, 0); check("R4 depth one", q1_v, 0);
    cyc1(1, 8'h56, 0, 0, 1); check("R11 ready after cancel", e1_r, 1); check("R5 depth one gone", q1_v, 0);
    cyc1(0, 0, 1, 0, 1); check("R9 depth one valid", q1_v, 1); check("R9 depth one data", q1_d, 8'h56);
    cyc1(0, 0, 0, 0, 1); check("R11 empty after take", q1_v, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule